// File: doc/BRIEF.md
# Process Address-Space Termination Control Register

This block is the per-accelerator control register that host software uses to stop all work for one process address-space identifier (PASID). Software writes a 32-bit word that holds a 20-bit PASID and a busy flag. When the flag is written as 1 and no termination is already running, the block stores the PASID. It then raises a one-cycle request toward the accelerator core, with the stored PASID beside it.

The flag stays set until the core acknowledges that every piece of work tagged with that PASID has drained. The block then clears the flag, and software, which polls the register, sees that the termination is complete. A write that arrives while a termination is running is dropped, so an unfinished request cannot be overwritten. The draining itself takes place in the core, and here it appears only as the acknowledge input.

Top module: `pasid_term_ctrl`

## Requirements
- R1: While reset is held, and after it is released, the readback word is zero and no request is raised.
- R2: A write with bit 20 set while the flag is clear stores bits 19:0 as the PASID. From the following cycle the readback shows that PASID, with bit 20 reading 1.
- R3: The accepted start write gives exactly one cycle of `term_req`, in the cycle after the write, and `term_pasid` then equals the stored PASID.
- R4: Bit 20 stays 1 until `term_ack` is sampled high. It reads 0 from the cycle after that sample, and an acknowledge during the request cycle itself also counts.
- R5: A write while bit 20 reads 1 is ignored: the PASID, the flag and `term_req` are unchanged. This includes a write in the same cycle as the acknowledge.
- R6: A write with bit 20 clear while idle updates the PASID field only. It raises no request and leaves the flag at 0.
- R7: Bits 31:21 always read 0, whatever data was written.
- R8: `term_ack` sampled while no termination is running has no effect on the readback or on `term_req`.
- R9: A new start write is accepted in the first cycle in which bit 20 reads 0 after a completed termination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Dword write strobe for this register |
| cfg_wdata | input | 32 | Write data: PASID in 19:0, start flag in 20 |
| cfg_rdata | output | 32 | Readback: PASID in 19:0, busy flag in 20, zero above |
| term_req | output | 1 | One-cycle termination request to the core |
| term_pasid | output | 20 | PASID to be drained, valid with `term_req` |
| term_ack | input | 1 | Core reports that the PASID has drained |

## Verification
The properties assume that `cfg_wr`, `cfg_wdata` and `term_ack` are known values, synchronous to `clk`, and stable around the rising edge. They also assume that the acknowledge may come at any time, including when no termination is running. The stimulus changes every input on the falling edge only. It raises `term_ack` while idle, in the request cycle and in the same cycle as a rejected write, so that the cases the properties allow are all driven.

// File: rtl/pasid_term_pkg.sv
package pasid_term_pkg;

  localparam int unsigned DEF_DATA_W  = 32;
  localparam int unsigned DEF_PASID_W = 20;

  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_REQ  = 2'd1,
    TS_WAIT = 2'd2
  } term_state_t;

endpackage

// File: rtl/pasid_term_rst_sync.sv
module pasid_term_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pasid_term_wrdec.sv
module pasid_term_wrdec #(
  parameter int unsigned PASID_W = 20
) (
  input  logic               cfg_wr,
  input  logic [PASID_W:0]   wr_field,
  input  logic               busy,
  output logic               load_pasid,
  output logic               start,
  output logic [PASID_W-1:0] new_pasid
);

  localparam int unsigned FLAG_BIT = PASID_W;

  logic accept;

  always_comb begin
    accept     = cfg_wr && !busy;
    load_pasid = accept;
    start      = accept && wr_field[FLAG_BIT];
    new_pasid  = wr_field[PASID_W-1:0];
  end

endmodule

// File: rtl/pasid_term_fsm.sv
module pasid_term_fsm
  import pasid_term_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic term_ack,
  output logic busy,
  output logic req_pulse
);

  term_state_t state_q;
  term_state_t state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TS_IDLE: if (start)    state_d = TS_REQ;
      TS_REQ:  state_d = term_ack ? TS_IDLE : TS_WAIT;
      TS_WAIT: if (term_ack) state_d = TS_IDLE;
      default: state_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TS_IDLE;
    else        state_q <= state_d;
  end

  assign busy      = (state_q != TS_IDLE);
  assign req_pulse = (state_q == TS_REQ);

endmodule

// File: rtl/pasid_term_store.sv
module pasid_term_store #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = en ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

endmodule

// File: rtl/pasid_term_ctrl.sv
module pasid_term_ctrl
  import pasid_term_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned PASID_W = DEF_PASID_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  output logic               term_req,
  output logic [PASID_W-1:0] term_pasid,
  input  logic               term_ack
);

  localparam int unsigned FLAG_BIT = PASID_W;
  localparam int unsigned PAD_W    = DATA_W - PASID_W - 1;

  logic               rst_sync_n;
  logic               busy;
  logic               load_pasid;
  logic               start;
  logic [PASID_W-1:0] new_pasid;
  logic [PASID_W-1:0] pasid_q;
  logic               unused_wdata_hi;

  assign unused_wdata_hi = ^cfg_wdata[DATA_W-1:FLAG_BIT+1];

  pasid_term_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pasid_term_wrdec #(.PASID_W(PASID_W)) u_wrdec (
    .cfg_wr     (cfg_wr),
    .wr_field   (cfg_wdata[FLAG_BIT:0]),
    .busy       (busy),
    .load_pasid (load_pasid),
    .start      (start),
    .new_pasid  (new_pasid)
  );

  pasid_term_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .term_ack  (term_ack),
    .busy      (busy),
    .req_pulse (term_req)
  );

  pasid_term_store #(.W(PASID_W)) u_store (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (load_pasid),
    .d     (new_pasid),
    .q     (pasid_q)
  );

  assign term_pasid = pasid_q;
  assign cfg_rdata  = {{PAD_W{1'b0}}, busy, pasid_q};

endmodule

// File: rtl/pasid_term_chk.sv
module pasid_term_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PASID_W = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_wr,
  input logic [DATA_W-1:0]  cfg_wdata,
  input logic [DATA_W-1:0]  cfg_rdata,
  input logic               term_req,
  input logic [PASID_W-1:0] term_pasid,
  input logic               term_ack
);

  localparam int unsigned FLAG_BIT = PASID_W;

  logic flag;
  assign flag = cfg_rdata[FLAG_BIT];

  // R2
  start_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_wdata[FLAG_BIT] && !flag) |=> (flag && term_req));

  // R3
  req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_req |=> !term_req);

  // R3
  req_pasid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_req |-> (term_pasid == cfg_rdata[PASID_W-1:0] && flag));

  // R4
  ack_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && term_ack) |=> !flag);

  // R4
  flag_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !term_ack) |=> flag);

  // R5
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && cfg_wr) |=> ($stable(cfg_rdata[PASID_W-1:0]) && !term_req));

  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[DATA_W-1:FLAG_BIT+1] == '0);

  // R8
  idle_ack_harmless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !cfg_wr && term_ack) |=> ($stable(cfg_rdata) && !term_req));

endmodule

bind pasid_term_ctrl pasid_term_chk #(.DATA_W(DATA_W), .PASID_W(PASID_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cfg_wr     (cfg_wr),
  .cfg_wdata  (cfg_wdata),
  .cfg_rdata  (cfg_rdata),
  .term_req   (term_req),
  .term_pasid (term_pasid),
  .term_ack   (term_ack)
);

// File: tb/test_pasid_term_ctrl.sv
module test_pasid_term_ctrl;

  localparam int DW = 32;
  localparam int PW = 20;

  logic          clk;
  logic          rst_n;
  logic          cfg_wr;
  logic [DW-1:0] cfg_wdata;
  logic [DW-1:0] cfg_rdata;
  logic          term_req;
  logic [PW-1:0] term_pasid;
  logic          term_ack;

  int n_cmp;
  int n_bad;

  typedef struct {
    logic [DW-1:0] rdata;
    logic          req;
    logic [PW-1:0] pasid;
    string         tag;
  } exp_t;

  exp_t exp_q[$];

  logic          m_busy;
  logic [PW-1:0] m_pasid;

  pasid_term_ctrl i_pasid_term_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .term_req   (term_req),
    .term_pasid (term_pasid),
    .term_ack   (term_ack)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic step(input logic wr, input logic [DW-1:0] wd, input logic ack,
                      input string tag);
    exp_t e;
    logic req_n;
    @(negedge clk);
    cfg_wr    = wr;
    cfg_wdata = wd;
    term_ack  = ack;
    req_n = 1'b0;
    if (m_busy) begin
      if (ack) m_busy = 1'b0;
    end else if (wr) begin
      m_pasid = wd[PW-1:0];
      if (wd[PW]) begin
        m_busy = 1'b1;
        req_n  = 1'b1;
      end
    end
    e.rdata = {11'b0, m_busy, m_pasid};
    e.req   = req_n;
    e.pasid = m_pasid;
    e.tag   = tag;
    exp_q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_cmp++;
      if (cfg_rdata !== e.rdata || term_req !== e.req ||
          (e.req && term_pasid !== e.pasid)) begin
        n_bad++;
        $display("FAIL %s: rdata=%h req=%b pasid=%h expected rdata=%h req=%b pasid=%h",
                 e.tag, cfg_rdata, term_req, term_pasid, e.rdata, e.req, e.pasid);
      end
    end
  end

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    m_busy = 1'b0; m_pasid = '0;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; term_ack = 1'b0;
    #1;
    n_cmp++;
    if (cfg_rdata !== '0 || term_req !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 in reset: rdata=%h req=%b expected rdata=0 req=0", cfg_rdata, term_req);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    step(1'b0, '0, 1'b0, "R1 after reset");
    step(1'b1, 32'h001A_BCDE, 1'b0, "R2 R3 start write");
    step(1'b0, '0, 1'b0, "R3 pulse ends, R4 flag held");
    step(1'b1, 32'h0011_2345, 1'b0, "R5 write while busy");
    step(1'b0, '0, 1'b0, "R4 still waiting");
    step(1'b0, '0, 1'b0, "R4 still waiting");
    step(1'b0, '0, 1'b1, "R4 ack clears flag");
    step(1'b0, '0, 1'b1, "R8 ack while idle");
    step(1'b0, '0, 1'b0, "R8 idle after stray ack");
    step(1'b1, 32'hFFE0_0042, 1'b0, "R6 R7 plain pasid write");
    step(1'b0, '0, 1'b0, "R6 no request");
    step(1'b1, 32'hFFFF_FFFF, 1'b0, "R2 R7 start with all ones");
    step(1'b0, '0, 1'b1, "R4 ack in request cycle");
    step(1'b1, 32'h0010_0001, 1'b0, "R2 start again");
    step(1'b0, '0, 1'b0, "R4 waiting");
    step(1'b1, 32'h0010_0002, 1'b1, "R5 write with ack same cycle");
    step(1'b1, 32'h0010_0003, 1'b0, "R9 start right after completion");
    step(1'b0, '0, 1'b0, "R3 pulse ends");
    step(1'b0, '0, 1'b1, "R4 ack");
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 32'h0010_0000 | (i * 32'h1_1111), 1'b0, "R2 R9 sweep start");
      step(1'b0, '0, (i % 2) == 0, "R4 sweep ack");
      step(1'b0, '0, 1'b1, "R4 sweep ack");
    end
    step(1'b0, '0, 1'b0, "R1 final idle");
    @(negedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule